// File: doc/BRIEF.md
# Alarm Match and Status Interrupt Unit

This unit watches the running calendar time of a clock chip and compares it against two independent alarm settings. Every alarm setting holds six one-byte fields: seconds, minutes, hours, date, month and weekday. The top bit of each field says whether that field takes part in the comparison. An alarm fires when a one-second update arrives and every enabled field equals the live time. The result is recorded in a status byte. That same byte also carries a power-loss flag and a daylight-saving-adjusted flag.

Software clears the alarm flags by writing the status byte. A write can lower an alarm flag but never raise one. If auto-clear is enabled, completing a status read lowers the alarm flags that the reader saw when the read began. An alarm that fires while the read is in progress is kept.

An active-low interrupt line reports alarms in one of two modes. In pulse mode it produces a fixed-length low pulse, measured in millisecond ticks. In level mode it stays low while an enabled alarm flag is set. Register storage and the time counters live outside this unit.

Top module: `alarm_status_unit`

## Requirements
- R1: On a cycle with `sec_tick` high, alarm k sets its flag (status bit 4 for alarm 0, bit 5 for alarm 1) at that clock edge when every field whose enable bit (bit 7 of the field byte; field bytes packed seconds at [7:0], minutes [15:8], hours [23:16], date [31:24], month [39:32], weekday [47:40]) is 1 has bits [6:0] equal to the same bits of the time field; disabled fields are ignored.
- R2: An alarm with no field enabled never sets its flag, and no flag is set in a cycle without `sec_tick`.
- R3: A status write ANDs alarm flags with written bits 4 and 5, so it can clear them but never set them.
- R4: With `ctl_arst` = 1, `sr_rd_done` clears only the alarm flags that were set when `sr_rd_start` was seen; a flag set after `sr_rd_start` stays set.
- R5: With `ctl_arst` = 0, `sr_rd_done` leaves the alarm flags unchanged.
- R6: Bit 0 (power-loss flag) is 1 after reset, ignores status writes, clears on `time_wr`, and rises only through reset.
- R7: Bit 6 (daylight-adjusted) sets on `dst_fwd`, clears on `dst_rev`, can be forced to 1 by a status write with bit 6 = 1, and is held at 0 while `dst_enable` = 0.
- R8: The status byte is 8'h01 after reset; bits 7 and 3:1 always read 0.
- R9: With `ctl_im` = 1, an alarm hit of an alarm whose enable (`ctl_ale0`/`ctl_ale1`) is 1 drives `irq_n` low from the next edge for exactly `PULSE_MS` `ms_tick` pulses; a new hit restarts the count; a hit of a disabled alarm leaves `irq_n` high.
- R10: With `ctl_im` = 0, `irq_n` is low exactly while (bit 4 and `ctl_ale0`) or (bit 5 and `ctl_ale1`).
- R11: An alarm hit in the same cycle as a clearing status write or a read completion leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sec_tick | input | 1 | One-cycle strobe per one-second time update |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| tm_fields | input | 48 | Live BCD time fields, one byte each |
| alm0_cfg | input | 48 | Alarm 0 field bytes, bit 7 of each is the field enable |
| alm1_cfg | input | 48 | Alarm 1 field bytes, bit 7 of each is the field enable |
| ctl_arst | input | 1 | Auto-clear alarm flags after a completed status read |
| ctl_im | input | 1 | 1 selects pulse interrupt mode, 0 level mode |
| ctl_ale0 | input | 1 | Alarm 0 may drive the interrupt |
| ctl_ale1 | input | 1 | Alarm 1 may drive the interrupt |
| sr_wr_en | input | 1 | Status byte write strobe |
| sr_wr_data | input | 8 | Status byte write data |
| sr_rd_start | input | 1 | Status read has begun |
| sr_rd_done | input | 1 | Status read ended with a valid stop |
| time_wr | input | 1 | Valid write into the time section |
| dst_enable | input | 1 | Daylight-saving function enabled |
| dst_fwd | input | 1 | Forward daylight-saving event |
| dst_rev | input | 1 | Reverse daylight-saving event |
| status_o | output | 8 | Status byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The properties assume that every strobe input is a single-cycle pulse. They assume each `sr_rd_start` is followed by its own `sr_rd_done` before the next read begins, and that reset is held for at least two clock edges. The stimulus drives every input on the falling edge, raises each strobe for exactly one cycle, and never lets a read start and a read completion coincide. It also keeps reset low for three edges at start-up. Under those conditions the auto-clear snapshot and the interrupt pulse counter always start from a defined state.

// File: rtl/alm_pkg.sv
// Package: shared field layout and status bit positions for the alarm unit.
// Assumes one byte per time field; bit 7 of an alarm field is its enable.
package alm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 6;
    localparam int NUM_ALARMS = 2;
    localparam int VEC_W      = FIELD_W * NUM_FIELDS;

    // Field slot indices inside a packed time or alarm vector
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;
    localparam int F_MON  = 4;
    localparam int F_DOW  = 5;

    // Status byte bit positions
    localparam int ST_PWRLOSS = 0;
    localparam int ST_ALM0    = 4;
    localparam int ST_ALM1    = 5;
    localparam int ST_DSTADJ  = 6;

    localparam logic [7:0] STATUS_RESET = 8'h01;
endpackage

// File: rtl/alarm_match.sv
// Module: alarm_match
// Compares one alarm setting with the live time. A field takes part only
// when its top bit is set; an alarm with no field enabled never matches.
// Assumes time and alarm vectors share the same packing. Purely combinational.
module alarm_match #(
    parameter int FW = 8,
    parameter int NF = 6
) (
    input  logic [FW*NF-1:0] now_i,
    input  logic [FW*NF-1:0] cfg_i,
    output logic             match_o
);
    localparam int VW = FW - 1;

    logic [NF-1:0] en_w;
    logic [NF-1:0] ok_w;

    for (genvar f = 0; f < NF; f++) begin : g_field
        // Per field: enable bit and value equality of the lower bits
        assign en_w[f] = cfg_i[f*FW + FW - 1];
        assign ok_w[f] = !en_w[f] || (now_i[f*FW +: VW] == cfg_i[f*FW +: VW]);
    end

    // Match needs at least one enabled field and every enabled field equal
    always_comb begin
        match_o = (|en_w) && (&ok_w);
    end
endmodule

// File: rtl/status_flags.sv
// Module: status_flags
// Holds the status byte: alarm flags with write-to-clear and read auto-clear,
// the power-loss flag and the daylight-adjusted flag.
// Assumes single-cycle strobes and a read start before each read completion.
module status_flags
    import alm_pkg::*;
#(
    parameter int NA = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NA-1:0] hit_i,
    input  logic          wr_en_i,
    input  logic [7:0]    wr_data_i,
    input  logic          rd_start_i,
    input  logic          rd_done_i,
    input  logic          arst_i,
    input  logic          time_wr_i,
    input  logic          dst_en_i,
    input  logic          dst_fwd_i,
    input  logic          dst_rev_i,
    output logic [7:0]    status_o
);
    logic [NA-1:0] alm_q;
    logic [NA-1:0] seen_q;
    logic [NA-1:0] alm_d;
    logic [NA-1:0] wr_keep_w;
    logic          pwrloss_q;
    logic          dstadj_q;

    assign wr_keep_w = {wr_data_i[ST_ALM1], wr_data_i[ST_ALM0]};

    // Next alarm flags: clear by write or auto-clear, then set by hits
    always_comb begin
        alm_d = alm_q;
        if (wr_en_i) begin
            alm_d = alm_d & wr_keep_w;
        end
        if (rd_done_i && arst_i) begin
            alm_d = alm_d & ~seen_q;
        end
        alm_d = alm_d | hit_i;
    end

    // Alarm flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q <= '0;
        end else begin
            alm_q <= alm_d;
        end
    end

    // Snapshot of flags the reader observed when its read began
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (rd_start_i) begin
            seen_q <= alm_q;
        end else if (rd_done_i) begin
            seen_q <= '0;
        end
    end

    // Power-loss flag: set by reset, cleared by the first time write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwrloss_q <= STATUS_RESET[ST_PWRLOSS];
        end else if (time_wr_i) begin
            pwrloss_q <= 1'b0;
        end
    end

    // Daylight-adjusted flag: disable wins, then events, then forced set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dstadj_q <= 1'b0;
        end else if (!dst_en_i) begin
            dstadj_q <= 1'b0;
        end else if (dst_fwd_i) begin
            dstadj_q <= 1'b1;
        end else if (dst_rev_i) begin
            dstadj_q <= 1'b0;
        end else if (wr_en_i && wr_data_i[ST_DSTADJ]) begin
            dstadj_q <= 1'b1;
        end
    end

    // Assemble the status byte; unused bits read zero
    always_comb begin
        status_o             = '0;
        status_o[ST_PWRLOSS] = pwrloss_q;
        status_o[ST_ALM0]    = alm_q[0];
        status_o[ST_ALM1]    = alm_q[NA-1];
        status_o[ST_DSTADJ]  = dstadj_q;
    end
endmodule

// File: rtl/irq_driver.sv
// Module: irq_driver
// Drives the active-low interrupt: in pulse mode a low pulse lasting PULSE_MS
// millisecond ticks after each trigger, in level mode the inverted level input.
// Assumes the trigger is already qualified by mode and per-alarm enables.
module irq_driver #(
    parameter int PULSE_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick_i,
    input  logic trigger_i,
    input  logic pulse_mode_i,
    input  logic level_i,
    output logic irq_n_o
);
    localparam int CW = $clog2(PULSE_MS + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_MS);

    logic [CW-1:0] left_q;

    // Remaining pulse length in ms; a trigger reloads it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trigger_i) begin
            left_q <= LOAD;
        end else if (ms_tick_i && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Output selection by interrupt mode
    always_comb begin
        irq_n_o = pulse_mode_i ? (left_q == '0) : !level_i;
    end
endmodule

// File: rtl/alarm_status_unit.sv
// Module: alarm_status_unit (top)
// Matches the live time against two alarm settings on each one-second
// update, keeps the status byte and drives the active-low interrupt.
// Assumes single-cycle strobes and synchronous active-low reset.
module alarm_status_unit
    import alm_pkg::*;
#(
    parameter int PULSE_MS = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             ms_tick,
    input  logic [VEC_W-1:0] tm_fields,
    input  logic [VEC_W-1:0] alm0_cfg,
    input  logic [VEC_W-1:0] alm1_cfg,
    input  logic             ctl_arst,
    input  logic             ctl_im,
    input  logic             ctl_ale0,
    input  logic             ctl_ale1,
    input  logic             sr_wr_en,
    input  logic [7:0]       sr_wr_data,
    input  logic             sr_rd_start,
    input  logic             sr_rd_done,
    input  logic             time_wr,
    input  logic             dst_enable,
    input  logic             dst_fwd,
    input  logic             dst_rev,
    output logic [7:0]       status_o,
    output logic             irq_n
);
    logic [VEC_W-1:0]      cfg_w [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] match_w;
    logic [NUM_ALARMS-1:0] hit_w;
    logic [NUM_ALARMS-1:0] ale_w;
    logic                  trigger_w;
    logic                  level_w;

    assign cfg_w[0] = alm0_cfg;
    assign cfg_w[1] = alm1_cfg;
    assign ale_w    = {ctl_ale1, ctl_ale0};

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_match #(
            .FW(FIELD_W),
            .NF(NUM_FIELDS)
        ) match_i (
            .now_i  (tm_fields),
            .cfg_i  (cfg_w[a]),
            .match_o(match_w[a])
        );
        // A match counts only on the one-second update
        assign hit_w[a] = sec_tick && match_w[a];
    end

    status_flags #(
        .NA(NUM_ALARMS)
    ) flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit_w),
        .wr_en_i   (sr_wr_en),
        .wr_data_i (sr_wr_data),
        .rd_start_i(sr_rd_start),
        .rd_done_i (sr_rd_done),
        .arst_i    (ctl_arst),
        .time_wr_i (time_wr),
        .dst_en_i  (dst_enable),
        .dst_fwd_i (dst_fwd),
        .dst_rev_i (dst_rev),
        .status_o  (status_o)
    );

    // Interrupt sources qualified by per-alarm enables
    always_comb begin
        trigger_w = ctl_im && (|(hit_w & ale_w));
        level_w   = (status_o[ST_ALM0] && ctl_ale0) || (status_o[ST_ALM1] && ctl_ale1);
    end

    irq_driver #(
        .PULSE_MS(PULSE_MS)
    ) irq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick_i   (ms_tick),
        .trigger_i   (trigger_w),
        .pulse_mode_i(ctl_im),
        .level_i     (level_w),
        .irq_n_o     (irq_n)
    );
endmodule

// File: rtl/alarm_status_unit_chk.sv
// Module: alarm_status_unit_chk
// Temporal checks on the alarm unit's ports and its qualified hit signal.
// Assumes reset is held for at least two edges before checking starts.
module alarm_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] hit_w,
    input logic       ctl_im,
    input logic       ctl_arst,
    input logic [7:0] sr_wr_data,
    input logic       sr_wr_en,
    input logic       sr_rd_done,
    input logic       dst_enable,
    input logic [7:0] status_o,
    input logic       irq_n
);
    logic [1:0] rst_seen_q;
    logic       armed_w;

    // Arms the checks once reset has been applied for two edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen_q <= {rst_seen_q[0], 1'b1};
        end
    end
    assign armed_w = rst_seen_q[1];

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        (status_o[7] == 1'b0) && (status_o[3:1] == 3'b000));

    p_alm0_rise_on_hit_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        $rose(status_o[4]) |-> $past(hit_w[0]));

    p_alm1_rise_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        $rose(status_o[5]) |-> $past(hit_w[1]));

    p_write_cannot_set_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        (sr_wr_en && !sr_wr_data[4] && !hit_w[0]) |=> !status_o[4]);

    p_keep_without_arst_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        (!ctl_arst && sr_rd_done && !sr_wr_en && status_o[4]) |=> status_o[4]);

    p_pwrloss_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        !$rose(status_o[0]));

    p_dst_off_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        !dst_enable |=> !status_o[6]);

    p_pulse_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        (ctl_im && $past(ctl_im) && !irq_n && $past(irq_n)) |-> $past(hit_w != 2'b00));

    p_hit_wins_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed_w)
        hit_w[0] |=> status_o[4]);
endmodule

bind alarm_status_unit alarm_status_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_w     (hit_w),
    .ctl_im    (ctl_im),
    .ctl_arst  (ctl_arst),
    .sr_wr_data(sr_wr_data),
    .sr_wr_en  (sr_wr_en),
    .sr_rd_done(sr_rd_done),
    .dst_enable(dst_enable),
    .status_o  (status_o),
    .irq_n     (irq_n)
);

// File: tb/alarm_status_unit_tb_top.sv
// Bench for alarm_status_unit: a vector table for field matching, then
// directed tests for status clearing, auto-clear, flags and interrupt modes.
module alarm_status_unit_tb_top;
    localparam int PW = 8;
    localparam logic [47:0] TM = 48'h03_07_15_12_30_45;
    localparam logic [47:0] ALL_OFF = 48'h0;

    // {expected flag, alarm 0 setting}; the time is TM for every entry
    localparam logic [48:0] VECS [6] = '{
        {1'b1, 48'h83_87_95_92_B0_C5},
        {1'b0, 48'h83_87_95_92_B1_C5},
        {1'b1, 48'h00_01_01_00_00_C5},
        {1'b0, 48'h03_07_15_12_30_45},
        {1'b1, 48'h83_00_00_00_00_00},
        {1'b0, 48'h00_88_00_00_00_C5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0, ms_tick = 1'b0;
    logic [47:0] tm_fields = TM, alm0_cfg = ALL_OFF, alm1_cfg = ALL_OFF;
    logic        ctl_arst = 1'b0, ctl_im = 1'b0, ctl_ale0 = 1'b0, ctl_ale1 = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [7:0]  sr_wr_data = 8'h00;
    logic        sr_rd_start = 1'b0, sr_rd_done = 1'b0, time_wr = 1'b0;
    logic        dst_enable = 1'b0, dst_fwd = 1'b0, dst_rev = 1'b0;
    logic [7:0]  status_o;
    logic        irq_n;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    alarm_status_unit #(.PULSE_MS(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ms_tick(ms_tick),
        .tm_fields(tm_fields), .alm0_cfg(alm0_cfg), .alm1_cfg(alm1_cfg),
        .ctl_arst(ctl_arst), .ctl_im(ctl_im), .ctl_ale0(ctl_ale0), .ctl_ale1(ctl_ale1),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_start(sr_rd_start),
        .sr_rd_done(sr_rd_done), .time_wr(time_wr), .dst_enable(dst_enable),
        .dst_fwd(dst_fwd), .dst_rev(dst_rev), .status_o(status_o), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled on negedges
    task automatic step();
        @(negedge clk);
        sec_tick = 1'b0; ms_tick = 1'b0; sr_wr_en = 1'b0; sr_rd_start = 1'b0;
        sr_rd_done = 1'b0; time_wr = 1'b0; dst_fwd = 1'b0; dst_rev = 1'b0;
    endtask

    task automatic wr_status(input logic [7:0] d);
        sr_wr_en = 1'b1; sr_wr_data = d; step();
    endtask

    task automatic tick_sec();
        sec_tick = 1'b1; step();
    endtask

    task automatic ms_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; step();
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        rst_n = 1'b1;
        step();
        // R8 / R6: reset value
        chk("R8 reset status", status_o, 8'h01);
        chk("R10 reset irq_n", {7'b0, irq_n}, 8'h01);

        // R6: power-loss flag is read-only, clears on a time write
        wr_status(8'h00);
        chk("R6 write ignored", status_o, 8'h01);
        time_wr = 1'b1; step();
        chk("R6 cleared by time write", status_o, 8'h00);
        wr_status(8'h01);
        chk("R6 write cannot set", status_o, 8'h00);

        // R1 / R2: field match table
        for (int v = 0; v < 6; v++) begin
            alm0_cfg = VECS[v][47:0];
            tick_sec();
            chk($sformatf("R1 R2 vector %0d", v), {7'b0, status_o[4]}, {7'b0, VECS[v][48]});
            wr_status(8'h00);
        end

        // R2: full match but no one-second update
        alm0_cfg = VECS[0][47:0];
        step();
        chk("R2 no tick no match", status_o, 8'h00);

        // R3: write clears but never sets
        alm1_cfg = VECS[0][47:0];
        tick_sec();
        chk("R3 both flags set", status_o, 8'h30);
        wr_status(8'h10);
        chk("R3 clear alarm 1 only", status_o, 8'h10);
        wr_status(8'h30);
        chk("R3 write one does not set", status_o, 8'h10);
        wr_status(8'h00);
        chk("R3 clear all", status_o, 8'h00);

        // R11: hit beats a clearing write in the same cycle
        alm1_cfg = ALL_OFF;
        sec_tick = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 8'h00; step();
        chk("R11 hit wins over write", status_o, 8'h10);

        // R5: no auto-clear without the enable
        ctl_arst = 1'b0;
        sr_rd_start = 1'b1; step();
        sr_rd_done = 1'b1; step();
        chk("R5 read keeps flag", status_o, 8'h10);

        // R4: auto-clear of seen flags, new event during read kept
        ctl_arst = 1'b1;
        sr_rd_start = 1'b1; step();
        alm0_cfg = ALL_OFF; alm1_cfg = VECS[0][47:0];
        tick_sec();
        alm1_cfg = ALL_OFF;
        sr_rd_done = 1'b1; step();
        chk("R4 seen cleared new kept", status_o, 8'h20);
        sr_rd_start = 1'b1; step();
        sr_rd_done = 1'b1; step();
        chk("R4 second read clears", status_o, 8'h00);
        ctl_arst = 1'b0;

        // R7: daylight-adjusted flag
        dst_enable = 1'b1;
        dst_fwd = 1'b1; step();
        chk("R7 forward sets", status_o, 8'h40);
        dst_rev = 1'b1; step();
        chk("R7 reverse clears", status_o, 8'h00);
        wr_status(8'h40);
        chk("R7 write forces set", status_o, 8'h40);
        dst_enable = 1'b0; step();
        chk("R7 disable clears", status_o, 8'h00);
        dst_fwd = 1'b1; step();
        chk("R7 held while disabled", status_o, 8'h00);

        // R10: level mode
        ctl_im = 1'b0; ctl_ale0 = 1'b1;
        alm0_cfg = VECS[0][47:0];
        tick_sec();
        chk("R10 level low with flag", {7'b0, irq_n}, 8'h00);
        ctl_ale0 = 1'b0; #1;
        chk("R10 enable off releases", {7'b0, irq_n}, 8'h01);
        ctl_ale0 = 1'b1;
        wr_status(8'h00);
        chk("R10 flag cleared releases", {7'b0, irq_n}, 8'h01);

        // R9: pulse mode length and restart
        ctl_im = 1'b1;
        tick_sec();
        chk("R9 pulse starts", {7'b0, irq_n}, 8'h00);
        ms_ticks(PW - 1);
        chk("R9 still low before end", {7'b0, irq_n}, 8'h00);
        ms_ticks(1);
        chk("R9 pulse ends", {7'b0, irq_n}, 8'h01);
        tick_sec();
        ms_ticks(3);
        tick_sec();
        ms_ticks(PW - 1);
        chk("R9 restart extends pulse", {7'b0, irq_n}, 8'h00);
        ms_ticks(1);
        chk("R9 restarted pulse ends", {7'b0, irq_n}, 8'h01);
        ctl_ale0 = 1'b0;
        tick_sec();
        chk("R9 disabled alarm no pulse", {7'b0, irq_n}, 8'h01);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule